// File: doc/BRIEF.md
# Dual-Bank Micro-op Operand Executor

This block runs short field-arithmetic micro-ops on 256-bit operands kept in two register banks, called LO and HI. Each bank holds sixteen slots of eight 32-bit words. Word 0 is the least significant. A micro-op names a source bank, two source slots, a destination bank, a destination slot and a modulus choice. Every micro-op reads one bank and writes the other. The datapath handles one word per cycle.

Arithmetic is over the prime field with P = 2^255 - 19. Results may be left lazily reduced, below 2P, and are brought fully below P only when a micro-op asks for the 1P modulus. The usual way to do this is to add a slot that holds zero. A sign-merge micro-op prepares a compressed point. It copies a Y slot and folds the parity of an X slot into the top bit.

Multiplication and inversion are not built in. Such opcodes are refused with a flag. A host port writes operand words, such as constants and inputs, while the block is idle, and it reads result words back.

Top module: `uop_exec`

## Requirements
- R1: After reset, `busy`, `done`, `err_bank` and `err_unsup` are all low.
- R2: A MOVE (op_code 0) copies all eight words of slot `op_src_a` in bank `op_src_bank` into slot `op_dst` of the other bank. `done` is high in the 10th cycle after the accepting clock edge.
- R3: An ADD (op_code 1) writes a+b. If that sum is not below the selected modulus, the modulus is subtracted once. Modulus 2P is selected by `op_mod_1p`=0 and P by `op_mod_1p`=1.
- R4: A SUB (op_code 2) writes a-b. When a<b, the selected modulus is added once, and the result is taken modulo 2^256.
- R5: Adding a zero slot with `op_mod_1p`=1 maps a value in [P,2P) to value-P. With `op_mod_1p`=0 the value is left unchanged.
- R6: For ADD and SUB, `done` is high in the 18th cycle after the accepting edge, and `busy` stays high from that edge until `done`.
- R7: A micro-op whose `op_src_bank` equals `op_dst_bank` sets `err_bank` and writes no slot. It gives `done` in the 1st cycle after acceptance. Both error flags are cleared by the next micro-op that is accepted and valid.
- R8: op_code 3 (multiply) and codes 5 to 7 set `err_unsup`, write no slot and give `done` in the 1st cycle. An unsupported code takes precedence over a bank conflict.
- R9: SIGN (op_code 4) copies slot `op_src_b` to `op_dst` and ORs bit 0 of word 0 of slot `op_src_a` into bit 31 of word 7.
- R10: While `busy` is low, `host_we` writes `host_wdata` to word `host_word` of slot `host_slot` in bank `host_bank` (0=LO, 1=HI). `host_rdata` shows the addressed word in the cycle after the address is applied. Source slots are never modified by a micro-op.
- R11: `op_valid` while `busy` is high is ignored. It causes no write and no extra `done`.
- R12: `done` is a single-cycle pulse, raised exactly once for every accepted micro-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Micro-op request, accepted when `busy` is low |
| op_code | input | 3 | 0 MOVE, 1 ADD, 2 SUB, 3 MUL (refused), 4 SIGN |
| op_src_bank | input | 1 | Source bank, 0=LO 1=HI |
| op_src_a | input | 4 | First source slot (X for SIGN) |
| op_src_b | input | 4 | Second source slot (Y for SIGN) |
| op_dst_bank | input | 1 | Destination bank |
| op_dst | input | 4 | Destination slot |
| op_mod_1p | input | 1 | 0 selects 2P, 1 selects P |
| busy | output | 1 | A micro-op is in progress |
| done | output | 1 | One-cycle completion pulse |
| err_bank | output | 1 | Last micro-op refused: same bank |
| err_unsup | output | 1 | Last micro-op refused: unsupported code |
| host_we | input | 1 | Host word write strobe |
| host_bank | input | 1 | Host access bank |
| host_slot | input | 4 | Host access slot |
| host_word | input | 3 | Host access word index |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle after the address |

## Verification
Most datapath faults can only be seen at the ports once `done` has pulsed and the destination slot is read back. This applies to a carry that is not cleared before word 0, a correction decided from the wrong final flag, or a modulus word indexed wrongly. Each such fault corrupts a whole 256-bit result.

The directed cases put operands on the boundaries of the modulus: sums just under and just over P and 2P, and differences that borrow. This means a wrong correction decision changes the value read back. Sequencer faults show up sooner, as a `done` pulse in a cycle other than the 1st, 10th or 18th. Bank-routing faults show up as a source slot or a refused destination that no longer holds the value written before the micro-op.

// File: rtl/uop_pkg.sv
package uop_pkg;

  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 8;
  localparam int NUM_SLOTS = 16;

  localparam logic [2:0] OPC_MOVE = 3'd0;
  localparam logic [2:0] OPC_ADD  = 3'd1;
  localparam logic [2:0] OPC_SUB  = 3'd2;
  localparam logic [2:0] OPC_MUL  = 3'd3;
  localparam logic [2:0] OPC_SIGN = 3'd4;

  // Word idx of the modulus: P = 2^255-19 (sel_1p) or 2P = 2^256-38.
  function automatic logic [WORD_W-1:0] modulus_word(input logic sel_1p, input int idx,
                                                     input int nwords);
    logic [WORD_W-1:0] w;
    w = '1;
    if (sel_1p) begin
      if (idx == 0)               w = w - WORD_W'(18);
      else if (idx == nwords - 1) w = {1'b0, {(WORD_W-1){1'b1}}};
    end else begin
      if (idx == 0)               w = w - WORD_W'(37);
    end
    return w;
  endfunction

endpackage

// File: rtl/uop_bank.sv
module uop_bank #(
  parameter int W  = 32,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);
  localparam int DEPTH = 2 ** AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata_a <= mem[raddr_a];
    rdata_b <= mem[raddr_b];
  end
endmodule

// File: rtl/uop_word_alu.sv
module uop_word_alu #(
  parameter int W = 32
) (
  input  logic         sub_mode,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] m,
  input  logic         cin_p,
  input  logic         cin_a,
  output logic [W-1:0] res_p,
  output logic [W-1:0] res_a,
  output logic         cout_p,
  output logic         cout_a
);
  logic [W:0] t_p;
  logic [W:0] t_a;

  // Primary chain: a+b or a-b. Alternate chain: primary -/+ modulus.
  always_comb begin
    if (!sub_mode) begin
      t_p = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin_p};
      t_a = {1'b0, t_p[W-1:0]} - {1'b0, m} - {{W{1'b0}}, cin_a};
    end else begin
      t_p = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin_p};
      t_a = {1'b0, t_p[W-1:0]} + {1'b0, m} + {{W{1'b0}}, cin_a};
    end
  end

  assign res_p  = t_p[W-1:0];
  assign res_a  = t_a[W-1:0];
  assign cout_p = t_p[W];
  assign cout_a = t_a[W];
endmodule

// File: rtl/uop_seq.sv
module uop_seq #(
  parameter int NUM_WORDS = 8,
  parameter int IW        = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_ok,
  input  logic          start_bad,
  input  logic          two_pass,
  output logic          busy,
  output logic          done,
  output logic [IW-1:0] rd_idx,
  output logic          proc_v,
  output logic          proc_first,
  output logic [IW-1:0] proc_idx,
  output logic          wr_v,
  output logic [IW-1:0] wr_idx
);
  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE, S_FIN} seq_state_e;

  localparam int          CW       = IW + 1;
  localparam logic [CW-1:0] RD_LAST = CW'(NUM_WORDS);
  localparam logic [CW-1:0] WR_LAST = CW'(NUM_WORDS - 1);

  seq_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          two_q, two_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    two_d   = two_q;
    unique case (state_q)
      S_IDLE: begin
        if (start_bad) begin
          state_d = S_FIN;
        end else if (start_ok) begin
          state_d = S_READ;
          cnt_d   = '0;
          two_d   = two_pass;
        end
      end
      S_READ: begin
        if (cnt_q == RD_LAST) begin
          state_d = two_q ? S_WRITE : S_FIN;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      S_WRITE: begin
        if (cnt_q == WR_LAST) state_d = S_FIN;
        else                  cnt_d   = cnt_q + 1'b1;
      end
      S_FIN:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      two_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      two_q   <= two_d;
    end
  end

  assign busy       = (state_q != S_IDLE);
  assign done       = (state_q == S_FIN);
  assign rd_idx     = cnt_q[IW-1:0];
  assign proc_v     = (state_q == S_READ) && (cnt_q != '0);
  assign proc_first = (state_q == S_READ) && (cnt_q == CW'(1));
  assign proc_idx   = cnt_q[IW-1:0] - 1'b1;
  assign wr_v       = (state_q == S_WRITE);
  assign wr_idx     = cnt_q[IW-1:0];

  // R12: completion is a single-cycle pulse
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: once busy, stays busy until the completion cycle
  p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
endmodule

// File: rtl/uop_exec.sv
module uop_exec #(
  parameter int WORD_W    = uop_pkg::WORD_W,
  parameter int NUM_WORDS = uop_pkg::NUM_WORDS,
  parameter int NUM_SLOTS = uop_pkg::NUM_SLOTS
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         op_valid,
  input  logic [2:0]                   op_code,
  input  logic                         op_src_bank,
  input  logic [$clog2(NUM_SLOTS)-1:0] op_src_a,
  input  logic [$clog2(NUM_SLOTS)-1:0] op_src_b,
  input  logic                         op_dst_bank,
  input  logic [$clog2(NUM_SLOTS)-1:0] op_dst,
  input  logic                         op_mod_1p,
  output logic                         busy,
  output logic                         done,
  output logic                         err_bank,
  output logic                         err_unsup,
  input  logic                         host_we,
  input  logic                         host_bank,
  input  logic [$clog2(NUM_SLOTS)-1:0] host_slot,
  input  logic [$clog2(NUM_WORDS)-1:0] host_word,
  input  logic [WORD_W-1:0]            host_wdata,
  output logic [WORD_W-1:0]            host_rdata
);
  import uop_pkg::*;

  localparam int SW = $clog2(NUM_SLOTS);
  localparam int IW = $clog2(NUM_WORDS);
  localparam int AW = SW + IW;

  // Reset: asserted asynchronously, released on the clock.
  logic rst_s1, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  // Request decode
  logic accept, code_ok, same_bank, start_ok, start_bad, two_pass;
  assign accept    = op_valid && !busy;
  assign code_ok   = (op_code == OPC_MOVE) || (op_code == OPC_ADD) ||
                     (op_code == OPC_SUB)  || (op_code == OPC_SIGN);
  assign same_bank = (op_src_bank == op_dst_bank);
  assign start_ok  = accept && code_ok && !same_bank;
  assign start_bad = accept && !(code_ok && !same_bank);
  assign two_pass  = (op_code == OPC_ADD) || (op_code == OPC_SUB);

  // Latched micro-op
  logic [2:0]    code_q;
  logic          srcb_q, dstb_q, mod_q;
  logic [SW-1:0] sa_q, sb_q, dst_q;
  logic          e_bank_q, e_unsup_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      code_q <= OPC_MOVE;
      srcb_q <= 1'b0;
      dstb_q <= 1'b1;
      mod_q  <= 1'b0;
      sa_q   <= '0;
      sb_q   <= '0;
      dst_q  <= '0;
    end else if (start_ok) begin
      code_q <= op_code;
      srcb_q <= op_src_bank;
      dstb_q <= op_dst_bank;
      mod_q  <= op_mod_1p;
      sa_q   <= op_src_a;
      sb_q   <= op_src_b;
      dst_q  <= op_dst;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      e_bank_q  <= 1'b0;
      e_unsup_q <= 1'b0;
    end else if (accept) begin
      e_unsup_q <= !code_ok;
      e_bank_q  <= code_ok && same_bank;
    end
  end
  assign err_bank  = e_bank_q;
  assign err_unsup = e_unsup_q;

  // Sequencer
  logic          proc_v, proc_first, wr_v;
  logic [IW-1:0] rd_idx, proc_idx, wr_idx;

  uop_seq #(.NUM_WORDS(NUM_WORDS), .IW(IW)) i_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_ok   (start_ok),
    .start_bad  (start_bad),
    .two_pass   (two_pass),
    .busy       (busy),
    .done       (done),
    .rd_idx     (rd_idx),
    .proc_v     (proc_v),
    .proc_first (proc_first),
    .proc_idx   (proc_idx),
    .wr_v       (wr_v),
    .wr_idx     (wr_idx)
  );

  // Banks
  logic [AW-1:0]     raddr_a, raddr_b, waddr;
  logic [WORD_W-1:0] wdata;
  logic [1:0]        bank_we;
  logic [WORD_W-1:0] rd_a [2];
  logic [WORD_W-1:0] rd_b [2];

  assign raddr_a = busy ? {sa_q, rd_idx} : {host_slot, host_word};
  assign raddr_b = {sb_q, rd_idx};

  for (genvar g = 0; g < 2; g++) begin : g_bank
    uop_bank #(.W(WORD_W), .AW(AW)) i_bank (
      .clk     (clk),
      .we      (bank_we[g]),
      .waddr   (waddr),
      .wdata   (wdata),
      .raddr_a (raddr_a),
      .raddr_b (raddr_b),
      .rdata_a (rd_a[g]),
      .rdata_b (rd_b[g])
    );
  end

  logic host_bank_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) host_bank_q <= 1'b0;
    else             host_bank_q <= host_bank;
  end
  assign host_rdata = rd_a[host_bank_q];

  // Word datapath
  logic [WORD_W-1:0] opa_w, opb_w, mod_w, res_p, res_a;
  logic              cin_p, cin_a, cout_p, cout_a;
  logic              cp_q, ca_q, xlsb_q;

  assign opa_w = rd_a[srcb_q];
  assign opb_w = rd_b[srcb_q];
  assign mod_w = modulus_word(mod_q, int'(proc_idx), NUM_WORDS);
  assign cin_p = proc_first ? 1'b0 : cp_q;
  assign cin_a = proc_first ? 1'b0 : ca_q;

  uop_word_alu #(.W(WORD_W)) i_alu (
    .sub_mode (code_q == OPC_SUB),
    .a        (opa_w),
    .b        (opb_w),
    .m        (mod_w),
    .cin_p    (cin_p),
    .cin_a    (cin_a),
    .res_p    (res_p),
    .res_a    (res_a),
    .cout_p   (cout_p),
    .cout_a   (cout_a)
  );

  logic [WORD_W-1:0] prim_buf [NUM_WORDS];
  logic [WORD_W-1:0] alt_buf  [NUM_WORDS];

  always_ff @(posedge clk) begin
    if (proc_v) begin
      cp_q               <= cout_p;
      ca_q               <= cout_a;
      prim_buf[proc_idx] <= res_p;
      alt_buf[proc_idx]  <= res_a;
    end
    if (proc_first) xlsb_q <= opa_w[0];
  end

  // Sign merge for the top word of the Y operand
  logic              x_bit;
  logic [WORD_W-1:0] sign_w;
  assign x_bit  = proc_first ? opa_w[0] : xlsb_q;
  assign sign_w = opb_w | ((proc_idx == IW'(NUM_WORDS - 1)) && x_bit ?
                           {1'b1, {(WORD_W-1){1'b0}}} : '0);

  // Correction choice from the final chain flags
  logic need_alt;
  assign need_alt = (code_q == OPC_ADD) ? (cp_q || !ca_q) : cp_q;

  // Write arbitration
  logic              pass1_we, op_we, host_wr;
  logic [WORD_W-1:0] op_wdata;
  logic [IW-1:0]     op_widx;

  assign pass1_we = proc_v && ((code_q == OPC_MOVE) || (code_q == OPC_SIGN));
  assign op_we    = pass1_we || wr_v;
  assign op_widx  = pass1_we ? proc_idx : wr_idx;
  assign host_wr  = host_we && !busy;

  always_comb begin
    if (pass1_we)      op_wdata = (code_q == OPC_MOVE) ? opa_w : sign_w;
    else if (need_alt) op_wdata = alt_buf[wr_idx];
    else               op_wdata = prim_buf[wr_idx];
  end

  assign waddr      = op_we ? {dst_q, op_widx} : {host_slot, host_word};
  assign wdata      = op_we ? op_wdata : host_wdata;
  assign bank_we[0] = (op_we && !dstb_q) || (host_wr && !host_bank);
  assign bank_we[1] = (op_we &&  dstb_q) || (host_wr &&  host_bank);

  // R7: a same-bank request writes nothing
  p_reject_bank_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && !busy && op_src_bank == op_dst_bank) |=> (bank_we == 2'b00));

  // R8: an unsupported code writes nothing
  p_reject_code_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && !busy && !code_ok) |=> (bank_we == 2'b00));

  // R10: while an op runs, its source bank is never written
  p_src_untouched_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy |-> !bank_we[srcb_q]);
endmodule

// File: tb/test_uop_exec.sv
module test_uop_exec;
  localparam logic [256:0] P_VAL  = (257'd1 << 255) - 257'd19;
  localparam logic [256:0] P2_VAL = (257'd1 << 256) - 257'd38;

  logic        clk, rst_n;
  logic        op_valid, op_src_bank, op_dst_bank, op_mod_1p;
  logic [2:0]  op_code;
  logic [3:0]  op_src_a, op_src_b, op_dst;
  logic        busy, done, err_bank, err_unsup;
  logic        host_we, host_bank;
  logic [3:0]  host_slot;
  logic [2:0]  host_word;
  logic [31:0] host_wdata, host_rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  uop_exec i_uop_exec (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_src_bank(op_src_bank), .op_src_a(op_src_a), .op_src_b(op_src_b),
    .op_dst_bank(op_dst_bank), .op_dst(op_dst), .op_mod_1p(op_mod_1p),
    .busy(busy), .done(done), .err_bank(err_bank), .err_unsup(err_unsup),
    .host_we(host_we), .host_bank(host_bank), .host_slot(host_slot),
    .host_word(host_word), .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] ref_add(input logic [255:0] a, b, input bit m1);
    logic [256:0] s, m;
    m = m1 ? P_VAL : P2_VAL;
    s = {1'b0, a} + {1'b0, b};
    if (s >= m) s = s - m;
    return s[255:0];
  endfunction

  function automatic logic [255:0] ref_sub(input logic [255:0] a, b, input bit m1);
    logic [256:0] m;
    logic [255:0] d;
    m = m1 ? P_VAL : P2_VAL;
    d = a - b;
    if (a < b) d = d + m[255:0];
    return d;
  endfunction

  task automatic hwrite(input bit bank, input logic [3:0] slot, input logic [255:0] v);
    for (int w = 0; w < 8; w++) begin
      @(negedge clk);
      host_we = 1'b1; host_bank = bank; host_slot = slot;
      host_word = 3'(w); host_wdata = v[w*32 +: 32];
    end
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hread(input bit bank, input logic [3:0] slot, output logic [255:0] v);
    for (int w = 0; w < 8; w++) begin
      @(negedge clk);
      host_bank = bank; host_slot = slot; host_word = 3'(w);
      @(negedge clk);
      v[w*32 +: 32] = host_rdata;
    end
  endtask

  task automatic run_op(input logic [2:0] code, input bit sb, input logic [3:0] sa,
                        input logic [3:0] sbb, input bit db, input logic [3:0] d,
                        input bit m1, output int lat);
    @(negedge clk);
    op_code = code; op_src_bank = sb; op_src_a = sa; op_src_b = sbb;
    op_dst_bank = db; op_dst = d; op_mod_1p = m1; op_valid = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      op_valid = 1'b0;
      lat++;
    end while (!done && lat < 64);
    @(negedge clk);
    chk(!done, "R12 done pulse width", 256'(done), 256'd0);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !err_bank && !err_unsup, "R1 reset outputs",
        {252'd0, busy, done, err_bank, err_unsup}, 256'd0);
  endtask

  task automatic t_host;
    logic [255:0] v, r;
    v = {64'h0123456789abcdef, 64'hfedcba9876543210, 64'h0f1e2d3c4b5a6978, 64'h8796a5b4c3d2e1f0};
    hwrite(1'b1, 4'd15, v);
    hread(1'b1, 4'd15, r);
    chk(r == v, "R10 host write/read", r, v);
  endtask

  task automatic t_move;
    logic [255:0] a, r;
    int lat;
    a = {8{32'h5a5a_1234}} ^ 256'hdead;
    hwrite(1'b0, 4'd2, a);
    run_op(3'd0, 1'b0, 4'd2, 4'd0, 1'b1, 4'd5, 1'b0, lat);
    chk(lat == 10, "R2 move latency", 256'(lat), 256'd10);
    hread(1'b1, 4'd5, r);
    chk(r == a, "R2 move LO->HI", r, a);
    hread(1'b0, 4'd2, r);
    chk(r == a, "R10 source slot kept", r, a);
    run_op(3'd0, 1'b1, 4'd5, 4'd0, 1'b0, 4'd7, 1'b0, lat);
    hread(1'b0, 4'd7, r);
    chk(r == a, "R2 move HI->LO", r, a);
  endtask

  task automatic t_addsub(input bit is_sub, input logic [255:0] a, b, input bit m1,
                          input string tag);
    logic [255:0] r, e;
    int lat;
    hwrite(1'b0, 4'd2, a);
    hwrite(1'b0, 4'd3, b);
    run_op(is_sub ? 3'd2 : 3'd1, 1'b0, 4'd2, 4'd3, 1'b1, 4'd6, m1, lat);
    chk(lat == 18, "R6 add/sub latency", 256'(lat), 256'd18);
    hread(1'b1, 4'd6, r);
    e = is_sub ? ref_sub(a, b, m1) : ref_add(a, b, m1);
    chk(r == e, tag, r, e);
  endtask

  task automatic t_reduce;
    logic [255:0] x, r;
    int lat;
    x = P_VAL[255:0] + 256'd7;
    hwrite(1'b1, 4'd4, x);
    hwrite(1'b1, 4'd0, 256'd0);
    run_op(3'd1, 1'b1, 4'd4, 4'd0, 1'b0, 4'd8, 1'b1, lat);
    hread(1'b0, 4'd8, r);
    chk(r == 256'd7, "R5 full reduction to 1P", r, 256'd7);
    run_op(3'd1, 1'b1, 4'd4, 4'd0, 1'b0, 4'd8, 1'b0, lat);
    hread(1'b0, 4'd8, r);
    chk(r == x, "R5 lazy 2P keeps value", r, x);
  endtask

  task automatic t_reject;
    logic [255:0] k, r;
    int lat;
    k = 256'h1111_2222_3333_4444_5555_6666_7777_8888_9999;
    hwrite(1'b1, 4'd9, k);
    run_op(3'd0, 1'b1, 4'd2, 4'd0, 1'b1, 4'd9, 1'b0, lat);
    chk(lat == 1, "R7 reject latency", 256'(lat), 256'd1);
    chk(err_bank && !err_unsup, "R7 err_bank flag", {254'd0, err_bank, err_unsup}, 256'd2);
    hread(1'b1, 4'd9, r);
    chk(r == k, "R7 destination unchanged", r, k);
    hwrite(1'b0, 4'd10, k);
    run_op(3'd3, 1'b1, 4'd2, 4'd3, 1'b0, 4'd10, 1'b0, lat);
    chk(lat == 1 && err_unsup && !err_bank, "R8 MUL refused",
        {252'd0, 2'(lat), err_bank, err_unsup}, 256'd5);
    run_op(3'd6, 1'b1, 4'd2, 4'd3, 1'b1, 4'd10, 1'b0, lat);
    chk(err_unsup && !err_bank, "R8 code 6 refused, precedence",
        {254'd0, err_bank, err_unsup}, 256'd1);
    hread(1'b0, 4'd10, r);
    chk(r == k, "R8 destination unchanged", r, k);
    run_op(3'd0, 1'b0, 4'd10, 4'd0, 1'b1, 4'd11, 1'b0, lat);
    chk(!err_bank && !err_unsup, "R7 flags cleared by good op",
        {254'd0, err_bank, err_unsup}, 256'd0);
  endtask

  task automatic t_sign(input logic [255:0] x, y, input string tag);
    logic [255:0] r, e;
    int lat;
    hwrite(1'b0, 4'd11, x);
    hwrite(1'b0, 4'd12, y);
    run_op(3'd4, 1'b0, 4'd11, 4'd12, 1'b1, 4'd13, 1'b0, lat);
    hread(1'b1, 4'd13, r);
    e = y | ({255'd0, x[0]} << 255);
    chk(r == e, tag, r, e);
  endtask

  task automatic t_busy_ignore;
    logic [255:0] k, r, e;
    int dones;
    k = 256'hcafe_f00d;
    hwrite(1'b1, 4'd14, k);
    hwrite(1'b0, 4'd2, 256'd100);
    hwrite(1'b0, 4'd3, 256'd23);
    @(negedge clk);
    op_code = 3'd1; op_src_bank = 1'b0; op_src_a = 4'd2; op_src_b = 4'd3;
    op_dst_bank = 1'b1; op_dst = 4'd6; op_mod_1p = 1'b1; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    dones = 0;
    @(negedge clk);
    op_code = 3'd0; op_src_a = 4'd1; op_dst = 4'd14; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (done) dones++;
    end
    chk(dones == 1, "R11 one done for busy period", 256'(dones), 256'd1);
    hread(1'b1, 4'd14, r);
    chk(r == k, "R11 ignored op wrote nothing", r, k);
    hread(1'b1, 4'd6, r);
    e = 256'd123;
    chk(r == e, "R11 running op unaffected", r, e);
  endtask

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; op_src_bank = 1'b0;
    op_src_a = '0; op_src_b = '0; op_dst_bank = 1'b1; op_dst = '0; op_mod_1p = 1'b0;
    host_we = 1'b0; host_bank = 1'b0; host_slot = '0; host_word = '0; host_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_host();
    t_move();
    t_addsub(1'b0, 256'h1234_5678, 256'h9abc_def0, 1'b0, "R3 add small 2P");
    t_addsub(1'b0, P2_VAL[255:0] - 256'd5, 256'd10, 1'b0, "R3 add wraps 2P");
    t_addsub(1'b0, P_VAL[255:0] - 256'd1, 256'd2, 1'b1, "R3 add wraps 1P");
    t_addsub(1'b0, P_VAL[255:0] - 256'd1, 256'd1, 1'b1, "R3 add equals P");
    t_addsub(1'b0, P2_VAL[255:0] - 256'd1, P2_VAL[255:0] - 256'd1, 1'b0, "R3 add carry out");
    t_addsub(1'b1, 256'd9, 256'd7, 1'b1, "R4 sub no borrow");
    t_addsub(1'b1, 256'd5, 256'd7, 1'b1, "R4 sub borrow 1P");
    t_addsub(1'b1, 256'd5, 256'd7, 1'b0, "R4 sub borrow 2P");
    t_addsub(1'b1, {8{32'h0000_ffff}}, {8{32'hffff_0000}} >> 1, 1'b0, "R4 sub multiword");
    t_reduce();
    t_reject();
    t_sign(256'h3, 256'h1234, "R9 sign odd x");
    t_sign(256'h4, 256'h1234, "R9 sign even x");
    t_sign(256'h5, {1'b1, 255'h77}, "R9 sign top bit already set");
    t_busy_ignore();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule